// File: doc/BRIEF.md
# Guard-Band Integer Frequency Offset Search

This block estimates the integer part of a carrier frequency offset from post-FFT subcarrier samples. Each symbol contains a known run of spectrally empty bins. An integer offset of k subcarrier spacings moves that empty run by k bins. The block finds where the run has moved by looking for the window of minimum energy.

The search has two stages. The first stage compares the energy just below the nominal empty run with the energy just above it, and so chooses a direction. The second stage slides a fixed-width window over only the half-range on that side. It keeps a running window sum with a short FIFO and holds the smallest sum seen so far. The direction chosen in one symbol steers the search in the next symbol, so a stream of symbols with a constant offset settles after one symbol. Bins arrive in order with a valid strobe, and a start flag marks bin 0. The result is a signed offset in bins with a one-cycle done pulse.

Top module: `cfo_guard_search`

## Requirements
- R1: Bin power is re*re + im*im of the signed two's-complement inputs. The all-minimum input (re = im = -2^(DW-1)) in every bin gives a correct result with no wrap in any sum.
- R2: A bin is accepted only on a cycle with in_valid high. in_sym_start together with in_valid marks that bin as bin 0. Each further accepted bin is one index higher, and in_sym_start is ignored while in_valid is low.
- R3: Stage one sums power over bins G0-R..G0-1 (lower window) and bins G0+W..G0+W+R-1 (upper window). If the upper sum is no larger than the lower sum, the next symbol searches the positive side; otherwise it searches the negative side. After reset the positive side is used.
- R4: On the positive side, candidate windows start at bins G0..G0+R and the estimate is start-G0, in the range 0..R.
- R5: On the negative side, candidate windows start at bins G0-R..G0 and the estimate is start-G0, in the range -R..0.
- R6: The candidate with the smallest W-bin power sum wins. If several candidates are equal, the lowest start bin wins.
- R7: est_done is high for exactly one cycle per complete symbol. That cycle is the one after the last bin of the searched span is accepted: bin G0+R+W-1 on the positive side, or bin G0+W-1 on the negative side. A symbol cut short before that bin produces no pulse.
- R8: After reset, est_done is 0 and est_off is 0. est_off changes only in a cycle where est_done is high.
- R9: Idle cycles (in_valid low) anywhere in a symbol, whatever their data, leave the estimate identical to that of a gap-free stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies in_re, in_im and in_sym_start |
| in_sym_start | input | 1 | Marks the current valid bin as bin 0 |
| in_re | input | DW | Real part of the bin, signed |
| in_im | input | DW | Imaginary part of the bin, signed |
| est_off | output | EW | Signed integer offset estimate in bins |
| est_done | output | 1 | One-cycle pulse when est_off is updated |

## Verification
A wrong direction register from stage one shows up one symbol later. The estimate then falls on the opposite half-range, and the done pulse moves to the other side's last bin, so both the value and the timing break on the next symbol. A corrupted FIFO tap or running sum shifts the winning window within the same symbol. A wrong bin counter moves the done pulse away from the expected bin at once. The bench sweeps every offset from -R to R, with and without idle gaps. It also runs all-zero and all-maximum symbols and ties, and compares each done pulse and estimate with an arithmetic model of the requirements.

// File: rtl/cfo_gs_pkg.sv
package cfo_gs_pkg;

  typedef enum logic {
    SIDE_POS = 1'b0,
    SIDE_NEG = 1'b1
  } side_e;

  // First bin of the searched half-range.
  function automatic int span_lo(side_e s, int g0, int r);
    return (s == SIDE_NEG) ? (g0 - r) : g0;
  endfunction

  // Bin at which the last candidate window is complete.
  function automatic int span_last(side_e s, int g0, int r, int w);
    return span_lo(s, g0, r) + r + w - 1;
  endfunction

endpackage

// File: rtl/cfo_bin_power.sv
module cfo_bin_power #(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic signed [DW-1:0] re_i,
  input  logic signed [DW-1:0] im_i,
  output logic [PW-1:0]        pwr_o
);

  // Square of a signed sample; the most negative value still fits in PW bits.
  function automatic logic [PW-1:0] square(logic signed [DW-1:0] v);
    logic signed [PW-1:0] e;
    e = PW'(v);
    return PW'(e * e);
  endfunction

  assign pwr_o = square(re_i) + square(im_i);

endmodule

// File: rtl/cfo_window_sum.sv
module cfo_window_sum #(
  parameter int PW = 16,
  parameter int W  = 8,
  localparam int SW = PW + $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_i,
  input  logic [PW-1:0] pwr_i,
  output logic [SW-1:0] sum_next_o,
  output logic [SW-1:0] sum_q_o
);

  localparam logic [SW-1:0] SUM_MAX = SW'(W) << (PW - 1);

  logic [PW-1:0] tap [W];
  logic [SW-1:0] sum_q;

  // Newest power enters, the power leaving the FIFO is removed.
  assign sum_next_o = sum_q + SW'(pwr_i) - SW'(tap[W-1]);
  assign sum_q_o    = sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < W; k++) tap[k] <= '0;
      sum_q <= '0;
    end else if (shift_i) begin
      tap[0] <= pwr_i;
      for (int k = 1; k < W; k++) tap[k] <= tap[k-1];
      sum_q <= sum_next_o;
    end
  end

  // R1: a window of W bins never exceeds W maximum powers (no wrap of the subtract)
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q <= SUM_MAX);

endmodule

// File: rtl/cfo_side_detect.sv
module cfo_side_detect
  import cfo_gs_pkg::*;
#(
  parameter int PW = 16,
  parameter int CW = 6,
  parameter int G0 = 24,
  parameter int W  = 8,
  parameter int R  = 16,
  localparam int AW = PW + $clog2(R + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [CW-1:0] bin_i,
  input  logic [PW-1:0] pwr_i,
  output side_e         side_o,
  output logic          decide_o
);

  localparam logic [CW-1:0] LO_FIRST = CW'(G0 - R);
  localparam logic [CW-1:0] LO_LAST  = CW'(G0 - 1);
  localparam logic [CW-1:0] UP_FIRST = CW'(G0 + W);
  localparam logic [CW-1:0] UP_LAST  = CW'(G0 + W + R - 1);

  logic [AW-1:0] low_q, up_q, up_total;
  logic          in_low, in_up;
  side_e         side_q;

  assign in_low   = valid_i && (bin_i >= LO_FIRST) && (bin_i <= LO_LAST);
  assign in_up    = valid_i && (bin_i >= UP_FIRST) && (bin_i <= UP_LAST);
  assign decide_o = valid_i && (bin_i == UP_LAST);
  assign up_total = up_q + AW'(pwr_i);
  assign side_o   = side_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      up_q   <= '0;
      side_q <= SIDE_POS;
    end else begin
      if (in_low) low_q <= (bin_i == LO_FIRST) ? AW'(pwr_i) : low_q + AW'(pwr_i);
      if (in_up)  up_q  <= (bin_i == UP_FIRST) ? AW'(pwr_i) : up_total;
      if (decide_o) side_q <= (up_total <= low_q) ? SIDE_POS : SIDE_NEG;
    end
  end

  // R3: the direction only moves at the decision bin of the upper window
  a_r3_side_at_decision: assert property (@(posedge clk) disable iff (!rst_n)
    (side_q != $past(side_q)) |-> $past(decide_o));

endmodule

// File: rtl/cfo_min_search.sv
module cfo_min_search
  import cfo_gs_pkg::*;
#(
  parameter int SW = 19,
  parameter int CW = 6,
  parameter int G0 = 24,
  parameter int W  = 8,
  parameter int R  = 16,
  parameter int EW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [CW-1:0]        bin_i,
  input  side_e                side_i,
  input  logic [SW-1:0]        win_next_i,
  output logic signed [EW-1:0] est_o,
  output logic                 done_o
);

  localparam logic [CW-1:0] P_FIRST = CW'(span_lo(SIDE_POS, G0, R) + W - 1);
  localparam logic [CW-1:0] P_LAST  = CW'(span_last(SIDE_POS, G0, R, W));
  localparam logic [CW-1:0] N_FIRST = CW'(span_lo(SIDE_NEG, G0, R) + W - 1);
  localparam logic [CW-1:0] N_LAST  = CW'(span_last(SIDE_NEG, G0, R, W));
  localparam logic [CW-1:0] POS_MIN = CW'(G0 - R);
  localparam logic [CW-1:0] POS_MAX = CW'(G0 + R);

  // Index transform: window start position to signed offset from nominal.
  function automatic logic signed [EW-1:0] to_offset(logic [CW-1:0] pos);
    logic signed [CW:0] d;
    d = $signed({1'b0, pos}) - $signed((CW+1)'(G0));
    return EW'(d);
  endfunction

  logic [CW-1:0] first_bin, last_bin, win_start, final_pos, best_pos_q;
  logic [SW-1:0] best_q;
  logic          in_span, take, last_evt;
  logic signed [EW-1:0] est_q;
  logic          done_q;

  assign first_bin = (side_i == SIDE_NEG) ? N_FIRST : P_FIRST;
  assign last_bin  = (side_i == SIDE_NEG) ? N_LAST  : P_LAST;
  assign win_start = bin_i - CW'(W - 1);
  assign in_span   = valid_i && (bin_i >= first_bin) && (bin_i <= last_bin);
  // Strict compare: equal sums leave the earlier (lower) start in place.
  assign take      = in_span && ((bin_i == first_bin) || (win_next_i < best_q));
  assign last_evt  = valid_i && (bin_i == last_bin);
  assign final_pos = take ? win_start : best_pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_q     <= '0;
      best_pos_q <= CW'(G0);
      est_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      if (take) begin
        best_q     <= win_next_i;
        best_pos_q <= win_start;
      end
      done_q <= last_evt;
      if (last_evt) est_q <= to_offset(final_pos);
    end
  end

  assign est_o  = est_q;
  assign done_o = done_q;

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: the estimate moves only together with done
  a_r8_est_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(est_q) |-> done_q);

  // R4 / R5: the held minimum always lies inside the combined search range
  a_r6_best_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (best_pos_q >= POS_MIN) && (best_pos_q <= POS_MAX));

endmodule

// File: rtl/cfo_guard_search.sv
module cfo_guard_search
  import cfo_gs_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NFFT = 64,
  parameter int W    = 8,
  parameter int R    = 16,
  parameter int G0   = 24,
  localparam int EW  = $clog2(R + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sym_start,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic signed [EW-1:0] est_off,
  output logic                 est_done
);

  localparam int CW = $clog2(NFFT);
  localparam int PW = 2 * DW;
  localparam int SW = PW + $clog2(W + 1);

  logic [CW-1:0] cnt_q, bin_cur;
  logic [PW-1:0] pwr;
  logic [SW-1:0] win_next, win_q;
  side_e         side;
  logic          decide;

  // Bin index of the sample on the inputs this cycle.
  assign bin_cur = in_sym_start ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (in_valid) cnt_q <= bin_cur + CW'(1);
  end

  // R2: a marked start bin is followed by index 1
  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sym_start) |=> (cnt_q == CW'(1)));

  cfo_bin_power #(.DW(DW)) u_pwr (
    .re_i (in_re),
    .im_i (in_im),
    .pwr_o(pwr)
  );

  cfo_window_sum #(.PW(PW), .W(W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_i   (in_valid),
    .pwr_i     (pwr),
    .sum_next_o(win_next),
    .sum_q_o   (win_q)
  );

  cfo_side_detect #(.PW(PW), .CW(CW), .G0(G0), .W(W), .R(R)) u_side (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (in_valid),
    .bin_i   (bin_cur),
    .pwr_i   (pwr),
    .side_o  (side),
    .decide_o(decide)
  );

  cfo_min_search #(.SW(SW), .CW(CW), .G0(G0), .W(W), .R(R), .EW(EW)) u_min (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (in_valid),
    .bin_i     (bin_cur),
    .side_i    (side),
    .win_next_i(win_next),
    .est_o     (est_off),
    .done_o    (est_done)
  );

  // R3: decision and done coincide only at the positive side's last bin
  a_r3_decide_once: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> !decide);

  // R1: the window sum register tracks the combinational next value
  a_r1_win_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> (win_q == $past(win_next)));

endmodule

// File: tb/tb_cfo_guard_search.sv
`timescale 1ns/1ps
module tb_cfo_guard_search;

  localparam int DW = 8, NFFT = 64, W = 8, R = 16, G0 = 24, EW = 6;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_sym_start = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  wire  signed [EW-1:0] est_off;
  wire                  est_done;

  always #2 clk = ~clk;

  cfo_guard_search #(.DW(DW), .NFFT(NFFT), .W(W), .R(R), .G0(G0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym_start(in_sym_start),
    .in_re(in_re), .in_im(in_im), .est_off(est_off), .est_done(est_done)
  );

  int checks = 0, errors = 0;
  longint pw [NFFT];
  logic signed [DW-1:0] sre [NFFT], sim [NFFT];
  bit    side_neg = 1'b0;
  int    exp_est = 0, exp_end = -1000, held_est = 0, last_bin = -1, ndone = 0;
  string tag = "R4";

  task automatic chk(bit ok, string rq, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, expv);
    end
  endtask

  // Model of R6 on the searched half (R4/R5) with lowest-start tie rule.
  function automatic int model_est(bit neg);
    int lo = neg ? G0 - R : G0;
    longint best = -1;
    int bpos = lo;
    for (int s = lo; s <= lo + R; s++) begin
      longint acc = 0;
      for (int j = 0; j < W; j++) acc += pw[s + j];
      if (best < 0 || acc < best) begin best = acc; bpos = s; end
    end
    return bpos - G0;
  endfunction

  // Model of R3.
  function automatic bit model_side();
    longint lo_s = 0, up_s = 0;
    for (int b = G0 - R; b < G0; b++) lo_s += pw[b];
    for (int b = G0 + W; b < G0 + W + R; b++) up_s += pw[b];
    return up_s > lo_s;
  endfunction

  task automatic step(bit v, bit s, int b, logic signed [DW-1:0] re, logic signed [DW-1:0] im);
    @(negedge clk);
    if (est_done) begin
      ndone++;
      chk(last_bin == exp_end, "R7", last_bin, exp_end);
      chk(int'(est_off) == exp_est, tag, int'(est_off), exp_est);
      held_est = int'(est_off);
    end else begin
      chk(int'(est_off) == held_est, "R8", int'(est_off), held_est);
    end
    in_valid = v; in_sym_start = s; in_re = re; in_im = im;
    last_bin = v ? b : -1;
  endtask

  // mode 0: empty band at k; 1: all zero; 2: all minimum; 3: two empty bands
  task automatic build(int k, int mode);
    for (int b = 0; b < NFFT; b++) begin
      bit empty;
      empty = (b >= G0 + k && b < G0 + k + W) ||
              (mode == 3 && b >= G0 + k + W + 1 && b < G0 + k + 2 * W + 1);
      case (mode)
        1: begin sre[b] = 0; sim[b] = 0; end
        2: begin sre[b] = -128; sim[b] = -128; end
        default: begin
          sre[b] = empty ? 8'sd0 : DW'(20 + (b % 7));
          sim[b] = empty ? 8'sd0 : DW'(-(10 + (b % 5)));
        end
      endcase
      pw[b] = longint'(sre[b]) * sre[b] + longint'(sim[b]) * sim[b];
    end
  endtask

  task automatic send(int k, int mode, bit gaps, string label);
    build(k, mode);
    exp_est = model_est(side_neg);
    exp_end = side_neg ? G0 + W - 1 : G0 + R + W - 1;
    tag = label;
    ndone = 0;
    for (int b = 0; b < NFFT; b++) begin
      if (gaps && ((b * 5 + k + 64) % 3 == 0)) step(1'b0, 1'b1, -1, -128, 127);
      step(1'b1, b == 0, b, sre[b], sim[b]);
    end
    step(1'b0, 1'b0, -1, 0, 0);
    chk(ndone == 1, "R7", ndone, 1);
    side_neg = model_side();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(est_done == 1'b0, "R8", est_done, 0);
    chk(int'(est_off) == 0, "R8", int'(est_off), 0);
    rst_n = 1'b1;

    send(5, 0, 1'b0, "R3");                       // positive side after reset
    for (int k = -R; k <= R; k++) begin           // full offset sweep
      send(k, 0, k[0], k[0] ? "R9" : (k < 0 ? "R5" : "R4"));
      send(k, 0, 1'b0, k < 0 ? "R5" : "R4");
    end
    send(0, 1, 1'b0, "R6");                       // all equal, positive side -> 0
    send(-5, 0, 1'b0, "R5");                      // steer to negative side
    send(-5, 0, 1'b0, "R5");
    send(0, 1, 1'b0, "R6");                       // all equal, negative side -> -R
    send(0, 2, 1'b0, "R1");                       // all-minimum inputs
    send(0, 2, 1'b1, "R1");
    send(3, 3, 1'b0, "R6");                       // two empty windows tie
    send(3, 3, 1'b0, "R6");

    // R2/R7: a symbol cut short before its last search bin makes no done
    build(2, 0);
    exp_end = -1000; tag = "R2"; ndone = 0;
    for (int b = 0; b < 12; b++) step(1'b1, b == 0, b, sre[b], sim[b]);
    step(1'b0, 1'b0, -1, 0, 0);
    chk(ndone == 0, "R2", ndone, 0);
    send(2, 0, 1'b0, "R2");
    send(2, 0, 1'b1, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule